// File: doc/BRIEF.md
# SPI Serial-Memory Burst Reader

This block is an SPI master that fetches a run of consecutive bytes from a serial memory. The host supplies a 16-bit start address, a byte count and a one-cycle start pulse. The block drops chip select and sends the read opcode, then the upper and lower halves of the address. After that it sends one filler byte for each byte wanted. What the slave returns while the three header bytes go out is thrown away. What it returns during each filler byte is passed to the host as a one-cycle valid strobe with the data.

The slave moves through memory by itself, so the address is sent only once per burst. The block has its own serial clock divider and byte shifter. Clock polarity and phase are parameters, so the same block can serve slaves in different SPI modes. Chip select has enforced setup, hold and idle-gap times. A done pulse marks the end of each burst, and start pulses that arrive while a burst is under way are dropped.

Top module: `spi_burst_reader`

## Requirements
- R1: During and after reset, `cs_n_o` is high, `sck_o` sits at the idle level CPOL, and `busy_o`, `data_valid_o` and `done_o` are low. Whenever `busy_o` is low, `cs_n_o` is high.
- R2: After chip select falls, the first three bytes on `mosi_o` are READ_OP (default 8'h03), then `addr_i[15:8]`, then `addr_i[7:0]`, each sent most significant bit first.
- R3: The bytes returned on `miso_i` during the three header bytes never reach the output. A burst of N produces exactly N `data_valid_o` strobes, and all of them occur while `cs_n_o` is low.
- R4: Each data byte is obtained by sending the filler byte 8'h00. The byte sampled on `miso_i` during that filler, assembled most significant bit first, is presented on `data_o` with a one-cycle `data_valid_o` strobe.
- R5: Data bytes are delivered in the order the slave returns them, and the address is not resent. A burst that crosses 16'hFFFF yields the slave's wrapped sequence unchanged.
- R6: The CPOL and CPHA parameters select the SPI mode. With CPHA=0, `miso_i` is sampled on the leading SCK edge. With CPHA=1, it is sampled on the trailing edge. `sck_o` is at CPOL whenever chip select is high.
- R7: One half SCK period lasts CLK_DIV system clocks. The first SCK edge comes at least one half period after chip select falls. Chip select rises at least one half period after the last SCK edge. Chip select stays high for at least four half periods between bursts.
- R8: A start pulse while `busy_o` is high, including the inter-burst gap, is ignored. The running burst keeps its address and count, and no further burst follows.
- R9: `done_o` is a one-cycle pulse, raised in the cycle in which chip select rises, after the last `data_valid_o` of the burst.
- R10: A start pulse with `count_i` equal to 0 is ignored. `busy_o` stays low and chip select stays high.
- R11: Any count from 1 up to 2**CNT_W-1 (255 by default) delivers exactly that many bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to begin a burst |
| addr_i | input | 16 | Start address, sampled with start_i |
| count_i | input | CNT_W | Number of data bytes, sampled with start_i |
| busy_o | output | 1 | High from accepted start until the end of the chip-select gap |
| done_o | output | 1 | One-cycle pulse at burst completion |
| data_valid_o | output | 1 | Strobe marking a received data byte |
| data_o | output | 8 | Received data byte |
| sck_o | output | 1 | Serial clock to the slave |
| cs_n_o | output | 1 | Active-low chip select |
| mosi_o | output | 1 | Serial data to the slave |
| miso_i | input | 1 | Serial data from the slave |

## Verification
The bench models a memory slave. That slave returns fixed marker bytes during the header, so a design that leaked header replies would show extra strobes or shifted data. A burst that wraps at 16'hFFFF, a single-byte burst and a 255-byte burst check the count logic; an off-by-one there would drop or add a byte. A second instance in mode 3 catches a shifter that samples on the wrong edge, since every returned byte would then come back shifted by one bit. Start pulses during shifting and during the chip-select gap, and a zero-count start, are sent to catch a sequencer that restarts, extends or launches an empty burst. Chip-select setup, hold and gap times are measured in system clocks.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_SETUP,
    SQ_LOAD,
    SQ_SHIFT,
    SQ_HOLD,
    SQ_GAP
  } seq_state_t;

  localparam int HDR_BYTES  = 3;
  localparam int GAP_HALVES = 4;
  localparam int BITS_PER_XCHG_EDGES = 16;

endpackage

// File: rtl/spi_half_tick.sv
module spi_half_tick #(
  parameter int HALF = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  output logic tick_o
);

  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

  generate
    if (HALF == 1) begin : g_direct
      assign tick_o = run_i;
    end else begin : g_count
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk) begin
        if (rst || !run_i) begin
          cnt_q <= '0;
        end else if (cnt_q == CW'(HALF - 1)) begin
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end

      assign tick_o = run_i && (cnt_q == CW'(HALF - 1));

      AST_TICK_SPACED: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> !tick_o) else $error("tick repeated"); // R7
    end
  endgenerate

endmodule

// File: rtl/spi_byte_xchg.sv
module spi_byte_xchg #(
  parameter bit CPOL = 1'b0,
  parameter bit CPHA = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_i,
  input  logic       load_i,
  input  logic [7:0] tx_i,
  input  logic       miso_i,
  output logic       sck_o,
  output logic       mosi_o,
  output logic       done_o,
  output logic [7:0] rx_o
);

  import spi_burst_pkg::*;

  localparam int EW = $clog2(BITS_PER_XCHG_EDGES);
  localparam logic [EW-1:0] LAST_EDGE = EW'(BITS_PER_XCHG_EDGES - 1);

  logic          active_q;
  logic [EW-1:0] edge_q;
  logic [7:0]    sr_q;
  logic [7:0]    rx_q;
  logic          sck_q;
  logic          mosi_q;
  logic          done_q;

  logic lead_edge;
  logic do_sample;
  logic do_shift;

  assign lead_edge = ~edge_q[0];

  generate
    if (CPHA) begin : g_pha1
      assign do_sample = ~lead_edge;
      assign do_shift  = lead_edge;
    end else begin : g_pha0
      assign do_sample = lead_edge;
      assign do_shift  = ~lead_edge && (edge_q != LAST_EDGE);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      edge_q   <= '0;
      sr_q     <= '0;
      rx_q     <= '0;
      sck_q    <= CPOL;
      mosi_q   <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (load_i) begin
        active_q <= 1'b1;
        edge_q   <= '0;
        if (CPHA) begin
          sr_q <= tx_i;
        end else begin
          mosi_q <= tx_i[7];
          sr_q   <= {tx_i[6:0], 1'b0};
        end
      end else if (active_q && tick_i) begin
        sck_q  <= ~sck_q;
        edge_q <= edge_q + 1'b1;
        if (do_sample) begin
          rx_q <= {rx_q[6:0], miso_i};
        end
        if (do_shift) begin
          mosi_q <= sr_q[7];
          sr_q   <= {sr_q[6:0], 1'b0};
        end
        if (edge_q == LAST_EDGE) begin
          active_q <= 1'b0;
          done_q   <= 1'b1;
        end
      end
    end
  end

  assign sck_o  = sck_q;
  assign mosi_o = mosi_q;
  assign done_o = done_q;
  assign rx_o   = rx_q;

  AST_SCK_PARKED: assert property (@(posedge clk) disable iff (rst)
    !active_q |-> (sck_q == CPOL)) else $error("sck not parked"); // R6
  AST_SCK_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    !$stable(sck_q) |-> $past(tick_i)) else $error("sck moved without tick"); // R7

endmodule

// File: rtl/spi_burst_reader.sv
module spi_burst_reader #(
  parameter int       CLK_DIV = 4,
  parameter bit       CPOL    = 1'b0,
  parameter bit       CPHA    = 1'b0,
  parameter int       CNT_W   = 8,
  parameter bit [7:0] READ_OP = 8'h03,
  parameter bit [7:0] FILL    = 8'h00
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [15:0]      addr_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             data_valid_o,
  output logic [7:0]       data_o,
  output logic             sck_o,
  output logic             cs_n_o,
  output logic             mosi_o,
  input  logic             miso_i
);

  import spi_burst_pkg::*;

  localparam int HW = $clog2(HDR_BYTES + 1);
  localparam int GW = $clog2(GAP_HALVES);
  localparam logic [HW-1:0] HDR_DONE = HW'(HDR_BYTES);

  seq_state_t       state_q;
  logic [15:0]      addr_q;
  logic [CNT_W-1:0] left_q;
  logic [HW-1:0]    hdr_q;
  logic [GW-1:0]    gap_q;
  logic             busy_q;
  logic             cs_n_q;
  logic             valid_q;
  logic [7:0]       data_q;
  logic             done_q;

  logic       tick;
  logic       div_run;
  logic       xchg_load;
  logic [7:0] xchg_tx;
  logic       xchg_done;
  logic [7:0] xchg_rx;

  assign div_run = (state_q == SQ_SETUP) || (state_q == SQ_SHIFT) ||
                   (state_q == SQ_HOLD)  || (state_q == SQ_GAP);
  assign xchg_load = (state_q == SQ_LOAD);

  always_comb begin
    case (hdr_q)
      HW'(0):  xchg_tx = READ_OP;
      HW'(1):  xchg_tx = addr_q[15:8];
      HW'(2):  xchg_tx = addr_q[7:0];
      default: xchg_tx = FILL;
    endcase
  end

  spi_half_tick #(
    .HALF(CLK_DIV)
  ) u_div (
    .clk   (clk),
    .rst   (rst),
    .run_i (div_run),
    .tick_o(tick)
  );

  spi_byte_xchg #(
    .CPOL(CPOL),
    .CPHA(CPHA)
  ) u_xchg (
    .clk   (clk),
    .rst   (rst),
    .tick_i(tick),
    .load_i(xchg_load),
    .tx_i  (xchg_tx),
    .miso_i(miso_i),
    .sck_o (sck_o),
    .mosi_o(mosi_o),
    .done_o(xchg_done),
    .rx_o  (xchg_rx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SQ_IDLE;
      addr_q  <= '0;
      left_q  <= '0;
      hdr_q   <= '0;
      gap_q   <= '0;
      busy_q  <= 1'b0;
      cs_n_q  <= 1'b1;
      valid_q <= 1'b0;
      data_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      done_q  <= 1'b0;
      case (state_q)
        SQ_IDLE: begin
          if (start_i && (count_i != '0)) begin
            addr_q  <= addr_i;
            left_q  <= count_i;
            hdr_q   <= '0;
            busy_q  <= 1'b1;
            cs_n_q  <= 1'b0;
            state_q <= SQ_SETUP;
          end
        end
        SQ_SETUP: begin
          if (tick) state_q <= SQ_LOAD;
        end
        SQ_LOAD: begin
          state_q <= SQ_SHIFT;
        end
        SQ_SHIFT: begin
          if (xchg_done) begin
            if (hdr_q != HDR_DONE) begin
              hdr_q   <= hdr_q + 1'b1;
              state_q <= SQ_LOAD;
            end else begin
              valid_q <= 1'b1;
              data_q  <= xchg_rx;
              left_q  <= left_q - 1'b1;
              state_q <= (left_q == CNT_W'(1)) ? SQ_HOLD : SQ_LOAD;
            end
          end
        end
        SQ_HOLD: begin
          if (tick) begin
            cs_n_q  <= 1'b1;
            done_q  <= 1'b1;
            gap_q   <= '0;
            state_q <= SQ_GAP;
          end
        end
        SQ_GAP: begin
          if (tick) begin
            gap_q <= gap_q + 1'b1;
            if (gap_q == GW'(GAP_HALVES - 1)) begin
              busy_q  <= 1'b0;
              state_q <= SQ_IDLE;
            end
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  assign busy_o       = busy_q;
  assign cs_n_o       = cs_n_q;
  assign data_valid_o = valid_q;
  assign data_o       = data_q;
  assign done_o       = done_q;

  AST_IDLE_CS_HIGH: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> cs_n_o) else $error("cs low while idle"); // R1
  AST_VALID_IN_CS: assert property (@(posedge clk) disable iff (rst)
    data_valid_o |-> !cs_n_o) else $error("data outside select"); // R3
  AST_CS_SCK_IDLE: assert property (@(posedge clk) disable iff (rst)
    cs_n_o |-> (sck_o == CPOL)) else $error("sck active while deselected"); // R6
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (busy_o && start_i) |=> $stable(addr_q)) else $error("start taken while busy"); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o) else $error("done longer than a cycle"); // R9
  AST_DONE_AT_RELEASE: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $rose(cs_n_o)) else $error("done not at cs release"); // R9
  AST_NO_EMPTY_SHIFT: assert property (@(posedge clk) disable iff (rst)
    (state_q == SQ_SHIFT) |-> (left_q != '0)) else $error("shifting with zero left"); // R11

endmodule

// File: tb/spi_burst_reader_test.sv
module spi_slave_mem (
  input  logic cs_n,
  input  logic sck,
  input  logic mosi,
  output logic miso
);
  logic [7:0]  cur;
  logic [7:0]  rx;
  logic [2:0]  bitn;
  logic [7:0]  cmd;
  logic [7:0]  a_hi;
  logic [15:0] start_addr;
  logic [15:0] ptr;
  int          nbyte;
  int          ncs;
  int          fill_bad;

  function automatic logic [7:0] memf(input logic [15:0] a);
    return (a[7:0] * 8'd5) ^ a[15:8] ^ 8'h96;
  endfunction

  initial begin
    cur = 8'hC3; rx = '0; bitn = '0; cmd = '0; a_hi = '0;
    start_addr = '0; ptr = '0; nbyte = 0; ncs = 0; fill_bad = 0;
  end

  always @(negedge cs_n) begin
    ncs   = ncs + 1;
    nbyte = 0;
    bitn  = '0;
    cur   = 8'hC3;
  end

  always @(posedge sck) begin
    if (!cs_n) begin
      rx = {rx[6:0], mosi};
      if (bitn == 3'd7) begin
        bitn = '0;
        case (nbyte)
          0: begin cmd = rx; cur = 8'hA5; end
          1: begin a_hi = rx; cur = 8'h5A; end
          2: begin start_addr = {a_hi, rx}; ptr = {a_hi, rx}; cur = memf(ptr); ptr = ptr + 16'd1; end
          default: begin
            if (rx != 8'h00) fill_bad = fill_bad + 1;
            cur = memf(ptr); ptr = ptr + 16'd1;
          end
        endcase
        nbyte = nbyte + 1;
      end else begin
        bitn = bitn + 3'd1;
      end
    end
  end

  assign miso = cur[3'd7 - bitn];
endmodule

module spi_burst_reader_test;
  localparam int DIV0 = 3;
  localparam int DIV3 = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic        start0 = 1'b0, start3 = 1'b0;
  logic [15:0] addr0 = '0, addr3 = '0;
  logic [7:0]  cnt0 = '0, cnt3 = '0;
  logic        busy0, done0, val0, sck0, cs0, mosi0, miso0;
  logic        busy3, done3, val3, sck3, cs3, mosi3, miso3;
  logic [7:0]  dat0, dat3;

  spi_burst_reader #(.CLK_DIV(DIV0), .CPOL(1'b0), .CPHA(1'b0)) uut (
    .clk(clk), .rst(rst), .start_i(start0), .addr_i(addr0), .count_i(cnt0),
    .busy_o(busy0), .done_o(done0), .data_valid_o(val0), .data_o(dat0),
    .sck_o(sck0), .cs_n_o(cs0), .mosi_o(mosi0), .miso_i(miso0));

  spi_burst_reader #(.CLK_DIV(DIV3), .CPOL(1'b1), .CPHA(1'b1)) uut3 (
    .clk(clk), .rst(rst), .start_i(start3), .addr_i(addr3), .count_i(cnt3),
    .busy_o(busy3), .done_o(done3), .data_valid_o(val3), .data_o(dat3),
    .sck_o(sck3), .cs_n_o(cs3), .mosi_o(mosi3), .miso_i(miso3));

  spi_slave_mem m0 (.cs_n(cs0), .sck(sck0), .mosi(mosi0), .miso(miso0));
  spi_slave_mem m3 (.cs_n(cs3), .sck(sck3), .mosi(mosi3), .miso(miso3));

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  logic [7:0] got0 [0:511];
  logic [7:0] got3 [0:511];
  int ng0 = 0, ng3 = 0, nd0 = 0, nd3 = 0;
  int last_val0 = 0, done_cyc0 = 0;

  int min_setup = 1 << 30, min_hold = 1 << 30, min_gap = 1 << 30;
  int t_fall = 0, t_rise = 0, t_sck = 0;
  bit first_pend = 0, have_rise = 0;
  logic prev_cs = 1'b1, prev_sck = 1'b0;

  function automatic logic [7:0] memf(input logic [15:0] a);
    return (a[7:0] * 8'd5) ^ a[15:8] ^ 8'h96;
  endfunction

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (val0) begin got0[ng0 % 512] = dat0; ng0 = ng0 + 1; last_val0 = cyc; end
    if (done0) begin nd0 = nd0 + 1; done_cyc0 = cyc; end
    if (val3) begin got3[ng3 % 512] = dat3; ng3 = ng3 + 1; end
    if (done3) nd3 = nd3 + 1;
    if (!rst) begin
      if (prev_cs && !cs0) begin
        t_fall = cyc; first_pend = 1;
        if (have_rise && (cyc - t_rise) < min_gap) min_gap = cyc - t_rise;
      end
      if (sck0 != prev_sck) begin
        if (first_pend) begin
          if ((cyc - t_fall) < min_setup) min_setup = cyc - t_fall;
          first_pend = 0;
        end
        t_sck = cyc;
      end
      if (!prev_cs && cs0) begin
        if ((cyc - t_sck) < min_hold) min_hold = cyc - t_sck;
        t_rise = cyc; have_rise = 1;
      end
    end
    prev_cs = cs0;
    prev_sck = sck0;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk = n_chk + 1;
    if (!ok) begin
      n_bad = n_bad + 1;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_idle0();
    while (busy0) @(negedge clk);
  endtask

  task automatic burst0(input logic [15:0] a, input int n, input string req);
    int base_cs;
    int base_fb;
    base_cs = m0.ncs;
    base_fb = m0.fill_bad;
    ng0 = 0; nd0 = 0;
    @(negedge clk);
    addr0 = a; cnt0 = 8'(n); start0 = 1'b1;
    @(negedge clk);
    start0 = 1'b0;
    while (nd0 == 0) @(negedge clk);
    wait_idle0();
    chk(m0.ncs == base_cs + 1, {req, " one select"}, m0.ncs - base_cs, 1);
    chk(m0.cmd == 8'h03, "R2 opcode", m0.cmd, 8'h03);
    chk(m0.start_addr == a, "R2 address", m0.start_addr, a);
    chk(ng0 == n, "R3 strobe count", ng0, n);
    chk(m0.fill_bad == base_fb, "R4 filler zero", m0.fill_bad - base_fb, 0);
    for (int i = 0; i < n && i < 512; i++) begin
      chk(got0[i] == memf(a + 16'(i)), {req, " R4 R5 data"}, got0[i], memf(a + 16'(i)));
    end
    chk(nd0 == 1, "R9 done count", nd0, 1);
    chk(done_cyc0 > last_val0, "R9 done after last byte", done_cyc0, last_val0 + 1);
  endtask

  task automatic t_reset();
    chk(cs0 == 1'b1, "R1 cs high", cs0, 1);
    chk(sck0 == 1'b0, "R1 sck idle", sck0, 0);
    chk(busy0 == 1'b0 && val0 == 1'b0 && done0 == 1'b0, "R1 flags low", {busy0, val0, done0}, 0);
    chk(sck3 == 1'b1, "R6 mode3 sck idles high", sck3, 1);
  endtask

  task automatic t_zero_count();
    int base_cs;
    base_cs = m0.ncs;
    @(negedge clk);
    addr0 = 16'h2222; cnt0 = 8'd0; start0 = 1'b1;
    @(negedge clk);
    start0 = 1'b0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (busy0 || !cs0) begin
        chk(0, "R10 zero count started", {busy0, cs0}, 1);
        break;
      end
    end
    chk(m0.ncs == base_cs, "R10 no select", m0.ncs - base_cs, 0);
  endtask

  task automatic t_start_busy();
    int base_cs;
    base_cs = m0.ncs;
    ng0 = 0; nd0 = 0;
    @(negedge clk);
    addr0 = 16'h0100; cnt0 = 8'd3; start0 = 1'b1;
    @(negedge clk);
    start0 = 1'b0;
    repeat (60) @(negedge clk);
    addr0 = 16'h4000; cnt0 = 8'd7; start0 = 1'b1;
    @(negedge clk);
    start0 = 1'b0;
    while (nd0 == 0) @(negedge clk);
    @(negedge clk);
    chk(busy0 == 1'b1, "R8 busy in gap", busy0, 1);
    addr0 = 16'h5000; cnt0 = 8'd2; start0 = 1'b1;
    @(negedge clk);
    start0 = 1'b0;
    wait_idle0();
    repeat (200) @(negedge clk);
    chk(m0.ncs == base_cs + 1, "R8 single burst", m0.ncs - base_cs, 1);
    chk(ng0 == 3, "R8 byte count kept", ng0, 3);
    chk(m0.start_addr == 16'h0100, "R8 address kept", m0.start_addr, 16'h0100);
    for (int i = 0; i < 3; i++)
      chk(got0[i] == memf(16'h0100 + 16'(i)), "R8 data", got0[i], memf(16'h0100 + 16'(i)));
  endtask

  task automatic t_mode3();
    int base_cs;
    base_cs = m3.ncs;
    ng3 = 0; nd3 = 0;
    @(negedge clk);
    addr3 = 16'h8A7F; cnt3 = 8'd6; start3 = 1'b1;
    @(negedge clk);
    start3 = 1'b0;
    while (nd3 == 0) @(negedge clk);
    while (busy3) @(negedge clk);
    chk(m3.ncs == base_cs + 1, "R6 mode3 select", m3.ncs - base_cs, 1);
    chk(m3.cmd == 8'h03, "R6 mode3 opcode", m3.cmd, 8'h03);
    chk(m3.start_addr == 16'h8A7F, "R6 mode3 address", m3.start_addr, 16'h8A7F);
    chk(ng3 == 6, "R6 mode3 count", ng3, 6);
    for (int i = 0; i < 6; i++)
      chk(got3[i] == memf(16'h8A7F + 16'(i)), "R6 mode3 data", got3[i], memf(16'h8A7F + 16'(i)));
    chk(sck3 == 1'b1, "R6 mode3 parks high", sck3, 1);
  endtask

  task automatic t_timing();
    chk(min_setup >= DIV0, "R7 cs setup", min_setup, DIV0);
    chk(min_hold >= DIV0, "R7 cs hold", min_hold, DIV0);
    chk(min_gap >= 4 * DIV0, "R7 cs gap", min_gap, 4 * DIV0);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk = n_chk + 1;
    n_bad = n_bad + 1;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    burst0(16'h1234, 5, "R2");
    burst0(16'hFFFE, 4, "R5");
    burst0(16'h0777, 1, "R11");
    t_zero_count();
    t_start_busy();
    t_mode3();
    burst0(16'h0300, 255, "R11");
    t_timing();
    finish_run();
  end
endmodule